// File: doc/BRIEF.md
# Command-Completion Register Block

This block is the software-facing register file of a sideband-bus controller. A host reaches it over a plain 32-bit word bus with separate read and write strobes and a byte address. It holds a small array of 32-bit words. Most words are ordinary storage. A few have special meaning: a command word, an interrupt-enable word, a write-one-to-clear status word, and two data-buffer words, one for outbound data and one for inbound data.

Writing the fire bit of the command word completes a command at once. No serial traffic takes place. In the same clock edge, the block loads a fixed success completion code into both buffer words and posts a done event into the status word, masked by the enable word. A level interrupt output follows the status word. Software must clear pending status before the block accepts another fire.

Top module: `cmd_cpl_regs`

## Requirements
- R1: Reset clears every register word to zero. Reset also drives the interrupt output and the read data to zero.
- R2: A write to an in-range word stores all 32 data bits, and a read of that word returns the stored value. This holds for every word except the command word (byte 0x08) and the status word (byte 0x1C). Read data appears one clock edge after the read strobe.
- R3: The command word always reads as zero. A write to it with bit 0 clear changes no register and leaves the interrupt output unchanged.
- R4: A fire is a command-word write with bit 0 set. When the status word is zero, a fire is accepted. An accepted fire sets the outbound buffer (byte 0x20) and the inbound buffer (byte 0x30) to 0x40 in the same edge.
- R5: An accepted fire replaces the status word with the enable word (byte 0x18) ANDed with 0x1. When enable bit 0 is clear, status stays zero and no interrupt is raised.
- R6: A fire while the status word is nonzero is refused. Both buffers and the status word keep their values.
- R7: A write to the status word clears exactly the status bits that are 1 in the write data. All other status bits keep their values.
- R8: The interrupt output is a registered level that is 1 exactly when the status word is nonzero. It changes on the same edge as the status word.
- R9: Word addresses at or beyond 16 (byte 0x40 and up) read as zero. Writes to them change no register.
- R10: Address bits [1:0] are ignored. The word index is address bits [7:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Level interrupt |

## Verification
Every write takes effect at the rising edge that samples its strobe. That same edge updates the buffers, the status word and the interrupt output. Read data is due one edge after the read strobe. The bench drives each access on a falling edge, drops the strobe on the next falling edge, and samples the outputs at that point, exactly one rising edge later. A running model built from the requirements predicts every word. The bench reads back the whole array after each sweep, so it sees side effects on words that were not addressed.

// File: rtl/cmdcpl_pkg.sv
package cmdcpl_pkg;
   // Role a word plays inside the register array
   typedef enum logic [1:0] {
      WK_PLAIN = 2'd0,
      WK_CMD   = 2'd1,
      WK_STS   = 2'd2,
      WK_BUF   = 2'd3
   } word_kind_e;

   function automatic word_kind_e kind_of(int idx, int cmd_idx, int sts_idx,
                                          int wbuf_idx, int rbuf_idx);
      if (idx == cmd_idx) return WK_CMD;
      if (idx == sts_idx) return WK_STS;
      if (idx == wbuf_idx || idx == rbuf_idx) return WK_BUF;
      return WK_PLAIN;
   endfunction
endpackage

// File: rtl/cmdcpl_decode.sv
module cmdcpl_decode #(
   parameter int ADDR_W    = 8,
   parameter int NUM_WORDS = 16
) (
   input  logic [ADDR_W-1:0]            addr,
   output logic                         in_range,
   output logic [$clog2(NUM_WORDS)-1:0] idx,
   output logic [NUM_WORDS-1:0]         sel
);
   localparam int IDX_W = $clog2(NUM_WORDS);
   localparam int WA_W  = ADDR_W - 2;

   logic [WA_W-1:0] word_addr;
   logic [1:0]      unused_byte_lane;

   if (IDX_W > WA_W) begin : g_bad_width
      $error("cmdcpl_decode: address too narrow for NUM_WORDS");
   end

   assign unused_byte_lane = addr[1:0];
   assign word_addr        = addr[ADDR_W-1:2];
   assign in_range         = (32'(word_addr) < NUM_WORDS);
   assign idx              = word_addr[IDX_W-1:0];

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sel
      assign sel[i] = in_range && (32'(idx) == i);
   end
endmodule

// File: rtl/cmdcpl_fire.sv
module cmdcpl_fire #(
   parameter int DATA_W = 32
) (
   input  logic              cmd_wr,
   input  logic              fire_bit,
   input  logic [DATA_W-1:0] sts_q,
   input  logic [DATA_W-1:0] ien_q,
   output logic              fire_ok,
   output logic [DATA_W-1:0] sts_set
);
   localparam logic [DATA_W-1:0] DONE_EVT = DATA_W'(1);

   // Accept only with nothing pending; the event vector is masked by enable
   assign fire_ok = cmd_wr && fire_bit && (sts_q == '0);
   assign sts_set = ien_q & DONE_EVT;
endmodule

// File: rtl/cmdcpl_regfile.sv
module cmdcpl_regfile
   import cmdcpl_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter int                NUM_WORDS = 16,
   parameter int                CMD_IDX   = 2,
   parameter int                IEN_IDX   = 6,
   parameter int                STS_IDX   = 7,
   parameter int                WBUF_IDX  = 8,
   parameter int                RBUF_IDX  = 12,
   parameter logic [DATA_W-1:0] CPL_CODE  = DATA_W'(64)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wen,
   input  logic                         ren,
   input  logic [DATA_W-1:0]            wdata,
   input  logic [NUM_WORDS-1:0]         sel,
   input  logic                         rd_in_range,
   input  logic [$clog2(NUM_WORDS)-1:0] rd_idx,
   input  logic                         fire_ok,
   input  logic [DATA_W-1:0]            sts_set,
   output logic [DATA_W-1:0]            sts_q,
   output logic [DATA_W-1:0]            ien_q,
   output logic [DATA_W-1:0]            sts_next,
   output logic [DATA_W-1:0]            rdata
);
   logic [DATA_W-1:0] words [NUM_WORDS];

   always_comb begin
      sts_next = sts_q;
      if (fire_ok)
         sts_next = sts_set;
      else if (wen && sel[STS_IDX])
         sts_next = sts_q & ~wdata;
   end

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      localparam word_kind_e KIND = kind_of(i, CMD_IDX, STS_IDX, WBUF_IDX, RBUF_IDX);
      if (KIND == WK_CMD) begin : g_cmd
         logic unused_cmd_sel;
         assign unused_cmd_sel = sel[i];
         assign words[i]       = '0;
      end else if (KIND == WK_STS) begin : g_sts
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= sts_next;
         end
         assign words[i] = q;
      end else if (KIND == WK_BUF) begin : g_buf
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                q <= '0;
            else if (fire_ok)          q <= CPL_CODE;
            else if (wen && sel[i])    q <= wdata;
         end
         assign words[i] = q;
      end else begin : g_plain
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             q <= '0;
            else if (wen && sel[i]) q <= wdata;
         end
         assign words[i] = q;
      end
   end

   assign sts_q = words[STS_IDX];
   assign ien_q = words[IEN_IDX];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rdata <= '0;
      else if (ren) rdata <= rd_in_range ? words[rd_idx] : '0;
   end

   AST_FIRE_LOADS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      fire_ok |=> (words[WBUF_IDX] == CPL_CODE) && (words[RBUF_IDX] == CPL_CODE)); // R4
   AST_STS_REPLACED: assert property (@(posedge clk) disable iff (!rst_n)
      fire_ok |=> sts_q == $past(sts_set)); // R5
   AST_FIRE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && sel[CMD_IDX] && wdata[0] && sts_q != '0) |=>
         $stable(sts_q) && $stable(words[WBUF_IDX]) && $stable(words[RBUF_IDX])); // R6
   AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && sel[STS_IDX]) |=> sts_q == ($past(sts_q) & ~$past(wdata))); // R7
endmodule

// File: rtl/cmd_cpl_regs.sv
module cmd_cpl_regs #(
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 8,
   parameter int          NUM_WORDS = 16,
   parameter int          CMD_OFS   = 'h08,
   parameter int          IEN_OFS   = 'h18,
   parameter int          STS_OFS   = 'h1C,
   parameter int          WBUF_OFS  = 'h20,
   parameter int          RBUF_OFS  = 'h30,
   parameter logic [31:0] CPL_CODE  = 32'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wen,
   input  logic              bus_ren,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   localparam int IDX_W    = $clog2(NUM_WORDS);
   localparam int CMD_IDX  = CMD_OFS / 4;
   localparam int IEN_IDX  = IEN_OFS / 4;
   localparam int STS_IDX  = STS_OFS / 4;
   localparam int WBUF_IDX = WBUF_OFS / 4;
   localparam int RBUF_IDX = RBUF_OFS / 4;

   if (NUM_WORDS * 4 > (1 << ADDR_W)) begin : g_bad_span
      $error("cmd_cpl_regs: register array exceeds address space");
   end
   if ((CMD_OFS | IEN_OFS | STS_OFS | WBUF_OFS | RBUF_OFS) % 4 != 0) begin : g_bad_align
      $error("cmd_cpl_regs: offsets must be word aligned");
   end
   if (CMD_IDX >= NUM_WORDS || IEN_IDX >= NUM_WORDS || STS_IDX >= NUM_WORDS ||
       WBUF_IDX >= NUM_WORDS || RBUF_IDX >= NUM_WORDS) begin : g_bad_idx
      $error("cmd_cpl_regs: special word outside array");
   end
   if (CMD_IDX == STS_IDX || CMD_IDX == IEN_IDX || STS_IDX == IEN_IDX ||
       WBUF_IDX == RBUF_IDX) begin : g_bad_overlap
      $error("cmd_cpl_regs: special words overlap");
   end
   if (DATA_W < 32 && (CPL_CODE >> DATA_W) != 0) begin : g_bad_code
      $error("cmd_cpl_regs: completion code wider than data path");
   end

   logic                 in_range;
   logic [IDX_W-1:0]     idx;
   logic [NUM_WORDS-1:0] sel;
   logic                 fire_ok;
   logic [DATA_W-1:0]    sts_set, sts_q, ien_q, sts_next;
   logic                 irq_q;

   cmdcpl_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_decode (
      .addr(bus_addr), .in_range(in_range), .idx(idx), .sel(sel));

   cmdcpl_fire #(.DATA_W(DATA_W)) u_fire (
      .cmd_wr(bus_wen && sel[CMD_IDX]), .fire_bit(bus_wdata[0]),
      .sts_q(sts_q), .ien_q(ien_q), .fire_ok(fire_ok), .sts_set(sts_set));

   cmdcpl_regfile #(
      .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .CMD_IDX(CMD_IDX),
      .IEN_IDX(IEN_IDX), .STS_IDX(STS_IDX), .WBUF_IDX(WBUF_IDX),
      .RBUF_IDX(RBUF_IDX), .CPL_CODE(DATA_W'(CPL_CODE))
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wen(bus_wen), .ren(bus_ren),
      .wdata(bus_wdata), .sel(sel), .rd_in_range(in_range), .rd_idx(idx),
      .fire_ok(fire_ok), .sts_set(sts_set), .sts_q(sts_q), .ien_q(ien_q),
      .sts_next(sts_next), .rdata(bus_rdata));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= (sts_next != '0);
   end
   assign irq_o = irq_q;

   AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (sts_q != '0)); // R8
   AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ren && !in_range) |=> bus_rdata == '0); // R9
   AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ren && in_range && 32'(idx) == CMD_IDX) |=> bus_rdata == '0); // R3
endmodule

// File: tb/cmd_cpl_regs_tb.sv
module cmd_cpl_regs_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NW         = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wen = 1'b0, bus_ren = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;
   logic [31:0] mdl [NW];

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_cpl_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_ren(bus_ren),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Model update follows the requirement rules (word index = addr[7:2])
   task automatic bus_wr(logic [7:0] a, logic [31:0] d);
      int w;
      @(negedge clk);
      bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wen = 1'b0;
      w = int'(a[7:2]);
      if (w < NW) begin
         if (w == 2) begin
            if (d[0] && mdl[7] == 32'h0) begin
               mdl[8]  = 32'h40;
               mdl[12] = 32'h40;
               mdl[7]  = mdl[6] & 32'h1;
            end
         end else if (w == 7) begin
            mdl[7] = mdl[7] & ~d;
         end else begin
            mdl[w] = d;
         end
      end
   endtask

   task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_ren = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_ren = 1'b0;
      d = bus_rdata;
   endtask

   task automatic check_all(string req);
      logic [31:0] v;
      for (int i = 0; i < NW; i++) begin
         bus_rd(8'(i * 4), v);
         check(req, v, mdl[i]);
      end
      check(req, 32'(irq_o), 32'(mdl[7] != 0));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      for (int i = 0; i < NW; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      check("R1", 32'(irq_o), 32'h0);
      check("R1", bus_rdata, 32'h0);
      rst_n = 1'b1;
      check_all("R1");

      // R2: sweep every word with an arithmetic pattern
      for (int i = 0; i < NW; i++) bus_wr(8'(i * 4), 32'h9E37_79B9 * 32'(i + 1));
      check_all("R2");
      bus_rd(8'h08, v);
      check("R3", v, 32'h0);

      // R9: every out-of-range word address
      for (int a = 'h40; a <= 'hFC; a += 4) begin
         bus_wr(8'(a), ~32'(a));
         bus_rd(8'(a), v);
         check("R9", v, 32'h0);
      end
      check_all("R9");

      // R10: byte-lane bits ignored
      bus_wr(8'h07, 32'h5A5A_1234);
      bus_rd(8'h06, v);
      check("R10", v, 32'h5A5A_1234);
      bus_rd(8'h05, v);
      check("R10", v, mdl[1]);

      // R4/R5: fire with enable bit 0 clear
      bus_wr(8'h18, 32'h0);
      bus_wr(8'h20, 32'h1111);
      bus_wr(8'h30, 32'h2222);
      bus_wr(8'h08, 32'h1);
      bus_rd(8'h20, v); check("R4", v, 32'h40);
      bus_rd(8'h30, v); check("R4", v, 32'h40);
      bus_rd(8'h1C, v); check("R5", v, 32'h0);
      check("R5", 32'(irq_o), 32'h0);

      // R5/R8: fire with full enable, only bit 0 posts
      bus_wr(8'h18, 32'hFFFF_FFFF);
      bus_wr(8'h20, 32'h33);
      bus_wr(8'h30, 32'h44);
      bus_wr(8'h08, 32'h3);
      check("R8", 32'(irq_o), 32'h1);
      bus_rd(8'h1C, v); check("R5", v, 32'h1);
      bus_rd(8'h20, v); check("R4", v, 32'h40);

      // R6: refused while status pending
      bus_wr(8'h20, 32'h55);
      bus_wr(8'h30, 32'h66);
      bus_wr(8'h08, 32'h1);
      bus_rd(8'h20, v); check("R6", v, 32'h55);
      bus_rd(8'h30, v); check("R6", v, 32'h66);
      bus_rd(8'h1C, v); check("R6", v, 32'h1);

      // R7: write-one-to-clear
      bus_wr(8'h1C, 32'hFFFF_FFFE);
      bus_rd(8'h1C, v); check("R7", v, 32'h1);
      check("R7", 32'(irq_o), 32'h1);
      bus_wr(8'h1C, 32'h1);
      check("R8", 32'(irq_o), 32'h0);
      bus_rd(8'h1C, v); check("R7", v, 32'h0);

      // R3: command write with bit 0 clear does nothing
      bus_wr(8'h08, 32'hFFFF_FFFE);
      check("R3", 32'(irq_o), 32'h0);
      check_all("R3");

      // R8: fire again after clearing
      bus_wr(8'h08, 32'h1);
      check("R8", 32'(irq_o), 32'h1);
      check_all("R2");

      // R1: reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1", 32'(irq_o), 32'h0);
      rst_n = 1'b1;
      for (int i = 0; i < NW; i++) mdl[i] = '0;
      check_all("R1");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule